// File: doc/BRIEF.md
# Nine-Track Word/Frame Packing Formatter

This block sits between a 36-bit word datapath and an 8-bit tape frame channel. On the write path it takes words over a valid/ready handshake and emits data frames over a second valid/ready handshake. Each frame carries an odd-parity bit that serves as the ninth track. On the read path it takes frames, with their parity bit, and rebuilds words. The rebuilt words are delivered over a third handshake, and each one is tagged when any frame that fed it arrived with bad parity.

A two-bit packing selector chooses one of four layouts. Word bits are numbered 0 (most significant, vector bit 35) to 35 (least significant, vector bit 0). Within any frame, lower-numbered bits travel first, in the frame's most significant position. The selector is sampled only while the writer, or the reader, is between records. A record on the write side ends with the word flagged as last. On the read side it ends with the frame flagged as last.

Top module: `tape_frame_fmt`

## Requirements
- R1: After reset, no frame and no word is offered, the parity error flag is low, and both the word input and the frame input are ready.
- R2: Selector 0 (full-word) writes each word as five frames. Frames 1-4 carry bits 0-31, eight per frame. Frame 5 is four zero bits followed by bits 32-35.
- R3: Selector 1 (octet) writes each word as four frames carrying bits 0-31. Bits 32-35 are dropped.
- R4: Selector 2 (text) writes each word as five frames. Frame k (1-4) is a 0 bit followed by bits 7(k-1) to 7(k-1)+6. Frame 5 is bit 35 followed by bits 28-34.
- R5: Selector 3 (dense) writes a pair of words as nine frames. Frames 1-4 carry the first word's bits 0-31. Frame 5 carries the first word's bits 32-35, then the second word's bits 0-3. Frames 6-9 carry the second word's bits 4-35.
- R6: In dense mode, a record that ends on the first word of a pair is completed with zeros in place of the missing second word. The nine frames are still sent, and the odd-word output is high on the ninth frame only.
- R7: Every written frame carries a parity bit that makes the nine bits together hold an odd number of ones.
- R8: The read path rebuilds words from frames in each of the four layouts. In full-word mode the upper four bits of frame 5 are ignored. In octet mode bits 32-35 come back as zero. In dense mode, a last frame with the odd-word input high yields only the pair's first word.
- R9: A received frame with even parity sets the parity error flag, which stays set until reset. It also marks every word built from that frame.
- R10: A selector change takes effect only between records. Words and frames inside a record use the selector value sampled when the record started.
- R11: While an offered frame or word is not taken, it stays offered and its data and flags do not change.
- R12: The last-frame output is high only on the final frame of the record's final word group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Packing selector: 0 full-word, 1 octet, 2 text, 3 dense |
| wr_valid | input | 1 | Word to write is offered |
| wr_ready | output | 1 | Writer takes the offered word |
| wr_word | input | 36 | Word to write |
| wr_last | input | 1 | Offered word ends the record |
| tx_valid | output | 1 | Outgoing frame is offered |
| tx_ready | input | 1 | Channel takes the outgoing frame |
| tx_data | output | 8 | Outgoing frame data |
| tx_par | output | 1 | Outgoing frame parity track |
| tx_last | output | 1 | Final frame of the record |
| tx_odd | output | 1 | Dense record ended on a single word |
| rx_valid | input | 1 | Incoming frame is offered |
| rx_ready | output | 1 | Reader takes the incoming frame |
| rx_data | input | 8 | Incoming frame data |
| rx_par | input | 1 | Incoming frame parity track |
| rx_last | input | 1 | Incoming frame ends the record |
| rx_odd | input | 1 | With rx_last in dense mode: second word is padding |
| rd_valid | output | 1 | Rebuilt word is offered |
| rd_ready | input | 1 | Consumer takes the rebuilt word |
| rd_word | output | 36 | Rebuilt word |
| rd_perr | output | 1 | Rebuilt word used a frame with bad parity |
| perr_flag | output | 1 | Sticky parity error flag |

## Verification
A frame becomes visible on the channel in the cycle after the edge that accepts its word. Each later frame appears one edge after the previous one is taken. The bench therefore collects frames at falling edges whenever valid and ready are both high, and compares the collected list, not fixed cycle numbers, against layouts derived bit by bit from the requirements. A rebuilt word is offered one edge after its closing frame is taken and is collected the same way. Stall and selector-lock checks sample at falling edges while the handshake is held off, or while a record is open.

// File: rtl/tff_pkg.sv
package tff_pkg;
  localparam int WORD_W  = 36;
  localparam int FRAME_W = 8;
  localparam int CHAR_W  = 7;
  localparam int IDX_W   = 4;
  localparam int NIB_W   = WORD_W - 4 * FRAME_W;

  typedef enum logic [1:0] {
    PK_CORE  = 2'd0,
    PK_IND   = 2'd1,
    PK_ASCII = 2'd2,
    PK_DENSE = 2'd3
  } pk_mode_e;

  // index of the final frame in one word group for a layout
  function automatic logic [IDX_W-1:0] grp_last(pk_mode_e m);
    case (m)
      PK_IND:   return IDX_W'(3);
      PK_DENSE: return IDX_W'(8);
      default:  return IDX_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/tff_pack.sv
module tff_pack
  import tff_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  pk_mode_e           mode_i,
  input  logic               w_valid,
  output logic               w_ready,
  input  logic [WORD_W-1:0]  w_data,
  input  logic               w_last,
  output logic               f_valid,
  input  logic               f_ready,
  output logic [FRAME_W-1:0] f_data,
  output logic               f_par,
  output logic               f_last,
  output logic               f_odd
);
  logic              busy_q, busy_d, in_rec_q, in_rec_d, has_b_q, has_b_d, end_q, end_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] wa_q, wa_d, wb_q, wb_d;
  pk_mode_e          mode_q, mode_d;
  logic              dense, take_b, at_end, fire, acc;
  int                ix;

  assign dense   = (mode_q == PK_DENSE);
  assign take_b  = busy_q && dense && !has_b_q && !end_q;
  assign w_ready = !busy_q || take_b;
  assign f_valid = busy_q && !(dense && idx_q == IDX_W'(4) && !has_b_q && !end_q);
  assign at_end  = (idx_q == grp_last(mode_q));
  assign f_last  = at_end && end_q;
  assign f_odd   = f_last && dense && !has_b_q;
  assign fire    = f_valid && f_ready;
  assign acc     = w_valid && w_ready;
  assign ix      = int'(idx_q);

  always_comb begin
    f_data = '0;
    case (mode_q)
      PK_CORE:  f_data = (ix < 4) ? FRAME_W'(wa_q >> (28 - 8 * ix)) : {4'b0, wa_q[NIB_W-1:0]};
      PK_IND:   f_data = FRAME_W'(wa_q >> (28 - 8 * ix));
      PK_ASCII: f_data = (ix < 4) ? {1'b0, CHAR_W'(wa_q >> (29 - CHAR_W * ix))}
                                  : {wa_q[0], wa_q[7:1]};
      default: begin
        if (ix < 4)       f_data = FRAME_W'(wa_q >> (28 - 8 * ix));
        else if (ix == 4) f_data = {wa_q[NIB_W-1:0], wb_q[WORD_W-1 -: NIB_W]};
        else              f_data = FRAME_W'(wb_q >> (24 - 8 * (ix - 5)));
      end
    endcase
  end
  assign f_par = ~^f_data;

  always_comb begin
    busy_d = busy_q; in_rec_d = in_rec_q; has_b_d = has_b_q; end_d = end_q;
    idx_d = idx_q; wa_d = wa_q; wb_d = wb_q;
    mode_d = (!busy_q && !in_rec_q) ? mode_i : mode_q;
    if (acc && !busy_q) begin
      wa_d = w_data; wb_d = '0; has_b_d = 1'b0; idx_d = '0;
      busy_d = 1'b1; end_d = w_last; in_rec_d = !w_last;
    end else if (acc) begin
      wb_d = w_data; has_b_d = 1'b1; end_d = w_last; in_rec_d = !w_last;
    end
    if (fire) begin
      if (at_end) busy_d = 1'b0;
      else        idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; in_rec_q <= 1'b0; has_b_q <= 1'b0; end_q <= 1'b0;
      idx_q <= '0; wa_q <= '0; wb_q <= '0; mode_q <= PK_CORE;
    end else begin
      busy_q <= busy_d; in_rec_q <= in_rec_d; has_b_q <= has_b_d; end_q <= end_d;
      idx_q <= idx_d; wa_q <= wa_d; wb_q <= wb_d; mode_q <= mode_d;
    end
  end

  a_r11_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    f_valid && !f_ready |=> f_valid && $stable(f_data) && $stable(f_par) && $stable(f_last));
  a_r10_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q || in_rec_q) |=> $stable(mode_q));
  a_r6_odd_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    f_odd |-> f_last && mode_q == PK_DENSE);
  a_r2_core_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    f_valid && mode_q == PK_CORE && idx_q == IDX_W'(4) |-> f_data[7:4] == 4'b0);
endmodule

// File: rtl/tff_unpack.sv
module tff_unpack
  import tff_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  pk_mode_e           mode_i,
  input  logic               f_valid,
  output logic               f_ready,
  input  logic [FRAME_W-1:0] f_data,
  input  logic               f_par,
  input  logic               f_last,
  input  logic               f_odd,
  output logic               w_valid,
  input  logic               w_ready,
  output logic [WORD_W-1:0]  w_data,
  output logic               w_perr,
  output logic               perr_sticky
);
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              in_rec_q, in_rec_d, err_q, err_d, ov_q, ov_d, oe_q, oe_d, st_q, st_d;
  logic [WORD_W-1:0] acc_q, acc_d, ow_q, ow_d;
  pk_mode_e          mode_q, mode_use;
  logic              idle, bad, fire, emit, ebase, nerr;
  logic [WORD_W-1:0] base, nacc, wout;
  int                ix;

  function automatic logic [WORD_W-1:0] put8(logic [WORD_W-1:0] b, logic [FRAME_W-1:0] d, int sh);
    return (b & ~(WORD_W'(8'hFF) << sh)) | (WORD_W'(d) << sh);
  endfunction

  assign idle     = (idx_q == '0) && !in_rec_q;
  assign mode_use = idle ? mode_i : mode_q;
  assign f_ready  = !ov_q;
  assign bad      = ~^{f_data, f_par};
  assign fire     = f_valid && f_ready;
  assign base     = (idx_q == '0) ? '0 : acc_q;
  assign ebase    = (idx_q == '0) ? 1'b0 : err_q;
  assign ix       = int'(idx_q);

  always_comb begin
    nacc = base; nerr = ebase | bad; emit = 1'b0; wout = base;
    case (mode_use)
      PK_CORE: begin
        if (ix < 4) nacc = put8(base, f_data, 28 - 8 * ix);
        else begin nacc = {base[WORD_W-1:NIB_W], f_data[NIB_W-1:0]}; emit = 1'b1; wout = nacc; end
      end
      PK_IND: begin
        nacc = put8(base, f_data, 28 - 8 * ix);
        emit = (ix == 3); wout = nacc;
      end
      PK_ASCII: begin
        if (ix < 4) nacc = (base & ~(WORD_W'(7'h7F) << (29 - CHAR_W * ix)))
                         | (WORD_W'(f_data[6:0]) << (29 - CHAR_W * ix));
        else begin nacc = {base[WORD_W-1:8], f_data[6:0], f_data[7]}; emit = 1'b1; wout = nacc; end
      end
      default: begin
        if (ix < 4) nacc = put8(base, f_data, 28 - 8 * ix);
        else if (ix == 4) begin
          wout = {base[WORD_W-1:NIB_W], f_data[7:4]}; emit = 1'b1;
          nacc = {f_data[NIB_W-1:0], 32'b0}; nerr = bad;
        end else begin
          nacc = put8(base, f_data, 24 - 8 * (ix - 5));
          emit = (ix == 8) && !f_odd; wout = nacc;
        end
      end
    endcase
  end

  always_comb begin
    idx_d = idx_q; in_rec_d = in_rec_q; acc_d = acc_q; err_d = err_q;
    ov_d = ov_q; ow_d = ow_q; oe_d = oe_q; st_d = st_q;
    if (ov_q && w_ready) ov_d = 1'b0;
    if (fire) begin
      acc_d = nacc; err_d = nerr; in_rec_d = !f_last; st_d = st_q | bad;
      idx_d = (f_last || idx_q == grp_last(mode_use)) ? '0 : idx_q + 1'b1;
      if (emit) begin ov_d = 1'b1; ow_d = wout; oe_d = ebase | bad; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0; in_rec_q <= 1'b0; acc_q <= '0; err_q <= 1'b0; mode_q <= PK_CORE;
      ov_q <= 1'b0; ow_q <= '0; oe_q <= 1'b0; st_q <= 1'b0;
    end else begin
      idx_q <= idx_d; in_rec_q <= in_rec_d; acc_q <= acc_d; err_q <= err_d; mode_q <= mode_use;
      ov_q <= ov_d; ow_q <= ow_d; oe_q <= oe_d; st_q <= st_d;
    end
  end

  assign w_valid     = ov_q;
  assign w_data      = ow_q;
  assign w_perr      = oe_q;
  assign perr_sticky = st_q;

  a_r11_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_perr));
  a_r9_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
    perr_sticky |=> perr_sticky);
  a_r8_octet_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(w_valid) && mode_q == PK_IND |-> w_data[3:0] == 4'b0);
endmodule

// File: rtl/tape_frame_fmt.sv
module tape_frame_fmt
  import tff_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [WORD_W-1:0]  wr_word,
  input  logic               wr_last,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [FRAME_W-1:0] tx_data,
  output logic               tx_par,
  output logic               tx_last,
  output logic               tx_odd,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [FRAME_W-1:0] rx_data,
  input  logic               rx_par,
  input  logic               rx_last,
  input  logic               rx_odd,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [WORD_W-1:0]  rd_word,
  output logic               rd_perr,
  output logic               perr_flag
);
  logic [1:0] rs_q;
  logic       srst_n;
  pk_mode_e   mode_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];
  assign mode_e = pk_mode_e'(mode);

  tff_pack u_pack (
    .clk(clk), .rst_n(srst_n), .mode_i(mode_e),
    .w_valid(wr_valid), .w_ready(wr_ready), .w_data(wr_word), .w_last(wr_last),
    .f_valid(tx_valid), .f_ready(tx_ready), .f_data(tx_data), .f_par(tx_par),
    .f_last(tx_last), .f_odd(tx_odd)
  );

  tff_unpack u_unpack (
    .clk(clk), .rst_n(srst_n), .mode_i(mode_e),
    .f_valid(rx_valid), .f_ready(rx_ready), .f_data(rx_data), .f_par(rx_par),
    .f_last(rx_last), .f_odd(rx_odd),
    .w_valid(rd_valid), .w_ready(rd_ready), .w_data(rd_word), .w_perr(rd_perr),
    .perr_sticky(perr_flag)
  );
endmodule

// File: tb/tape_frame_fmt_tb_top.sv
`timescale 1ns/1ps
module tape_frame_fmt_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        wr_valid = 0, wr_last = 0, tx_ready = 1, rx_valid = 0, rx_par = 0;
  logic        rx_last = 0, rx_odd = 0, rd_ready = 1;
  logic [35:0] wr_word = '0;
  logic [7:0]  rx_data = '0;
  logic        wr_ready, tx_valid, tx_par, tx_last, tx_odd, rx_ready, rd_valid, rd_perr, perr_flag;
  logic [7:0]  tx_data;
  logic [35:0] rd_word;

  int n_tests = 0, n_fail = 0, ncap = 0, nrw = 0;
  logic [7:0]  cap_d [0:63];
  logic        cap_p [0:63], cap_l [0:63], cap_o [0:63];
  logic [35:0] rw [0:15];
  logic        re [0:15];

  always #2 clk = ~clk;

  tape_frame_fmt dut_i (.*);

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready && ncap < 64) begin
      cap_d[ncap] = tx_data; cap_p[ncap] = tx_par; cap_l[ncap] = tx_last; cap_o[ncap] = tx_odd;
      ncap++;
    end
    if (rst_n && rd_valid && rd_ready && nrw < 16) begin
      rw[nrw] = rd_word; re[nrw] = rd_perr; nrw++;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [35:0] act, input logic [35:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // expected frame i of a group, built from per-bit numbering (bit k = vector bit 35-k)
  function automatic logic [7:0] ef(int m, logic [35:0] a, logic [35:0] b, int i);
    logic [7:0] f = '0;
    for (int k = 0; k < 8; k++) begin
      case (m)
        0: f[7-k] = (i < 4) ? a[35-(8*i+k)] : ((k < 4) ? 1'b0 : a[35-(32+k-4)]);
        1: f[7-k] = a[35-(8*i+k)];
        2: if (i < 4) f[7-k] = (k == 0) ? 1'b0 : a[35-(7*i+k-1)];
           else       f[7-k] = (k == 0) ? a[0] : a[35-(28+k-1)];
        default:
          if (i < 4)       f[7-k] = a[35-(8*i+k)];
          else if (i == 4) f[7-k] = (k < 4) ? a[35-(32+k)] : b[35-(k-4)];
          else             f[7-k] = b[35-(4+8*(i-5)+k)];
      endcase
    end
    return f;
  endfunction

  task automatic push(input logic [35:0] w, input bit l);
    wr_valid = 1; wr_word = w; wr_last = l; #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic feed(input logic [7:0] d, input bit p, input bit l, input bit o);
    rx_valid = 1; rx_data = d; rx_par = p; rx_last = l; rx_odd = o; #1;
    while (!rx_ready) begin @(negedge clk); #1; end
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic feed_group(input int m, input logic [35:0] a, input logic [35:0] b,
                            input int nf, input bit l, input bit o);
    for (int i = 0; i < nf; i++) feed(ef(m, a, b, i), ~^ef(m, a, b, i), l && i == nf-1, o && i == nf-1);
  endtask

  task automatic settle();
    for (int t = 0; t < 40; t++) @(negedge clk);
  endtask

  task automatic chk_group(input string rq, input int m, input logic [35:0] a, input logic [35:0] b,
                           input int base, input int nf, input bit lst, input bit odd);
    for (int i = 0; i < nf; i++) begin
      check(cap_d[base+i] == ef(m, a, b, i), rq, 36'(cap_d[base+i]), 36'(ef(m, a, b, i)));
      check(^{cap_d[base+i], cap_p[base+i]} == 1'b1, "R7 parity", 36'(cap_p[base+i]), 36'(~^cap_d[base+i]));
      check(cap_l[base+i] == (lst && i == nf-1), "R12 last", 36'(cap_l[base+i]), 36'(lst && i == nf-1));
      check(cap_o[base+i] == (odd && i == nf-1), "R6 odd", 36'(cap_o[base+i]), 36'(odd && i == nf-1));
    end
  endtask

  localparam logic [35:0] W1 = 36'h9DEADBEE5;
  localparam logic [35:0] W2 = 36'h3C0FFEE7A;
  localparam logic [35:0] WT = {7'h48, 7'h45, 7'h4C, 7'h4C, 7'h4F, 1'b1};
  localparam logic [35:0] WA = 36'hA12345678, WB = 36'h5FEDCBA98, WC = 36'hC3A5A5A5C;

  task automatic t_reset();
    check(tx_valid == 0, "R1 tx_valid", 36'(tx_valid), 0);
    check(rd_valid == 0, "R1 rd_valid", 36'(rd_valid), 0);
    check(perr_flag == 0, "R1 perr_flag", 36'(perr_flag), 0);
    check(wr_ready == 1 && rx_ready == 1, "R1 ready", 36'({wr_ready, rx_ready}), 36'h3);
  endtask

  task automatic t_write_single(input int m, input logic [35:0] w, input int nf, input string rq);
    mode = 2'(m); @(negedge clk); ncap = 0;
    push(w, 1); settle();
    check(ncap == nf, {rq, " count"}, 36'(ncap), 36'(nf));
    chk_group(rq, m, w, '0, 0, nf, 1, 0);
  endtask

  task automatic t_dense();
    mode = 2'd3; @(negedge clk); ncap = 0;
    push(WA, 0); push(WB, 0); push(WC, 1); settle();
    check(ncap == 18, "R5 count", 36'(ncap), 36'd18);
    chk_group("R5 pair", 3, WA, WB, 0, 9, 0, 0);
    chk_group("R6 odd pad", 3, WC, '0, 9, 9, 1, 1);
  endtask

  task automatic t_mode_lock();
    mode = 2'd0; @(negedge clk); ncap = 0;
    push(W1, 0); mode = 2'd1; push(W2, 1); settle();
    check(ncap == 10, "R10 count in record", 36'(ncap), 36'd10);
    chk_group("R10 first", 0, W1, '0, 0, 5, 0, 0);
    chk_group("R10 second", 0, W2, '0, 5, 5, 1, 0);
    ncap = 0; push(W1, 1); settle();
    check(ncap == 4, "R10 new record", 36'(ncap), 36'd4);
    chk_group("R10 octet", 1, W1, '0, 0, 4, 1, 0);
  endtask

  task automatic t_stall();
    logic [7:0] d0;
    mode = 2'd0; @(negedge clk); ncap = 0; tx_ready = 0;
    push(W2, 1); @(negedge clk); d0 = tx_data;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(tx_valid == 1 && tx_data == d0, "R11 stall hold", 36'(tx_data), 36'(d0));
    end
    tx_ready = 1; settle();
    check(ncap == 5, "R11 count", 36'(ncap), 36'd5);
    chk_group("R11 after stall", 0, W2, '0, 0, 5, 1, 0);
  endtask

  task automatic t_read();
    mode = 2'd0; @(negedge clk); nrw = 0;
    for (int i = 0; i < 4; i++) feed(ef(0, W1, 0, i), ~^ef(0, W1, 0, i), 0, 0);
    feed({4'hA, W1[3:0]}, ~^{4'hA, W1[3:0]}, 1, 0); settle();
    check(nrw == 1 && rw[0] == W1 && re[0] == 0, "R8 full-word", rw[0], W1);
    mode = 2'd1; @(negedge clk); nrw = 0;
    feed_group(1, W2, 0, 4, 1, 0); settle();
    check(nrw == 1 && rw[0] == {W2[35:4], 4'h0}, "R8 octet", rw[0], {W2[35:4], 4'h0});
    mode = 2'd2; @(negedge clk); nrw = 0;
    feed_group(2, WT, 0, 5, 1, 0); settle();
    check(nrw == 1 && rw[0] == WT, "R8 text", rw[0], WT);
    mode = 2'd3; @(negedge clk); nrw = 0;
    feed_group(3, WA, WB, 9, 0, 0); feed_group(3, WC, 0, 9, 1, 1); settle();
    check(nrw == 3, "R8 dense count", 36'(nrw), 36'd3);
    check(rw[0] == WA && rw[1] == WB && rw[2] == WC, "R8 dense words", rw[2], WC);
  endtask

  task automatic t_perr();
    mode = 2'd0; @(negedge clk); nrw = 0;
    check(perr_flag == 0, "R9 flag clear before", 36'(perr_flag), 0);
    for (int i = 0; i < 5; i++)
      feed(ef(0, W2, 0, i), (i == 2) ? ^ef(0, W2, 0, i) : ~^ef(0, W2, 0, i), i == 4, 0);
    settle();
    check(nrw == 1 && rw[0] == W2 && re[0] == 1, "R9 word marked", 36'(re[0]), 36'd1);
    check(perr_flag == 1, "R9 flag set", 36'(perr_flag), 1);
    feed_group(0, W1, 0, 5, 1, 0); settle();
    check(nrw == 2 && re[1] == 0, "R9 clean word", 36'(re[1]), 0);
    check(perr_flag == 1, "R9 flag sticky", 36'(perr_flag), 1);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_single(0, W1, 5, "R2 full-word");
    t_write_single(1, W2, 4, "R3 octet");
    t_write_single(2, WT, 5, "R4 text");
    t_dense();
    t_mode_lock();
    t_stall();
    t_read();
    t_perr();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule